// File: doc/BRIEF.md
# Software Trap Entry and Return Controller

This block sequences the architectural side effects of a software trap instruction and of the matching exception return. When a valid trap instruction passes its condition check, the controller does five things in one step. It redirects fetch to a fixed vector. It stores the address of the following instruction in the supervisor-bank link register. It copies the current program status word into the supervisor saved-status register. It switches the mode field to supervisor and sets the interrupt mask bit. The user-bank link register is not touched.

A return instruction reloads the program counter from the link register of the current bank. In supervisor mode the same step also restores the status word from the saved copy. In user mode there is no saved copy, so only the program counter is reloaded.

Between events, the core's flag update and link-register write-back pass through the controller so that they land in the correct bank. All state changes take effect at the clock edge after the request. The redirect output is a one-cycle pulse that goes with the new target address.

Top module: `swtrap_ctrl`

## Requirements
- R1: A taken trap (`insn_vld`=1, `cond_ok`=1, `is_trap`=1) makes `pc_redirect` 1 one cycle later, with `pc_target` equal to `VEC_ADDR` (default 0x0000_0008).
- R2: A taken trap loads `lr_svc` with the trapping instruction address `cur_pc` plus `INSN_BYTES` (default 4).
- R3: A taken trap loads `spsr_svc` with the value `cpsr` held before the trap, in either mode.
- R4: After a taken trap, `cpsr[4:0]` is 0x13 (supervisor) and `cpsr[7]` (interrupt mask) is 1. The flags `cpsr[31:28]` and all other bits keep their value from before the trap.
- R5: Trap entry leaves `lr_usr` unchanged.
- R6: A taken return while `cpsr[4:0]`=0x13 pulses `pc_redirect`, sets `pc_target` to `lr_svc`, and sets `cpsr` to `spsr_svc`, all at the same edge.
- R7: A taken return while `cpsr[4:0]`=0x10 (user) pulses `pc_redirect` with `pc_target` equal to `lr_usr`, and leaves `cpsr` unchanged.
- R8: With `insn_vld`=0 or `cond_ok`=0, the trap and return indications have no effect: there is no redirect and no change to `cpsr`, `spsr_svc`, `lr_usr` or `lr_svc`.
- R9: If `is_trap` and `is_ret` are both asserted, the trap is taken. A taken trap or return in the same cycle as `flag_wr` or `lr_wr` discards that write.
- R10: Synchronous reset sets `cpsr` to 0x0000_0010 and `spsr_svc`, `lr_usr`, `lr_svc` to zero, and clears `pc_redirect`.
- R11: With no taken event, `flag_wr` copies `flag_val` into `cpsr[31:28]`, and `lr_wr` writes `lr_val` into the link register of the current mode (`lr_usr` in user mode, `lr_svc` in supervisor mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_vld | input | 1 | An instruction is presented this cycle |
| is_trap | input | 1 | Decoded software trap instruction |
| is_ret | input | 1 | Decoded exception return instruction |
| cond_ok | input | 1 | Condition code check passed |
| cur_pc | input | DW | Address of the presented instruction |
| flag_wr | input | 1 | Condition flag update request |
| flag_val | input | 4 | New condition flags, N Z C V |
| lr_wr | input | 1 | Link register write-back request |
| lr_val | input | DW | Link register write-back data |
| pc_redirect | output | 1 | One-cycle fetch redirect pulse |
| pc_target | output | DW | Redirect address |
| cpsr | output | 32 | Current program status word |
| spsr_svc | output | 32 | Supervisor saved-status register |
| lr_usr | output | DW | User-bank link register |
| lr_svc | output | DW | Supervisor-bank link register |

## Verification
The bench builds the controller with its defaults: a 32-bit address path, a vector at 0x8 and a 4-byte instruction step. With these values the expected link and vector values match the usual word-aligned trap layout. It also lets addresses near the top of the space wrap when the step is added. A reference model steps the banked state alongside the design. It covers nested traps taken from supervisor mode, returns from both modes, and simultaneous trap/return and write-back requests, so the bank selection and priority rules are exercised from every mode.

// File: rtl/swtrap_pkg.sv
package swtrap_pkg;

    localparam logic [4:0] MODE_USR = 5'h10;
    localparam logic [4:0] MODE_SVC = 5'h13;

    typedef struct packed {
        logic [3:0]  nzcv;
        logic [19:0] rsvd;
        logic        irq_off;
        logic        fiq_off;
        logic        thumb;
        logic [4:0]  mode;
    } psr_t;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_TRAP = 2'd1,
        EV_RET  = 2'd2
    } ev_e;

    localparam psr_t PSR_RESET = '{nzcv: 4'h0, rsvd: 20'h0, irq_off: 1'b0,
                                   fiq_off: 1'b0, thumb: 1'b0, mode: MODE_USR};

    function automatic psr_t enter_svc(input psr_t p);
        psr_t r;
        r         = p;
        r.mode    = MODE_SVC;
        r.irq_off = 1'b1;
        return r;
    endfunction

    function automatic logic is_svc(input psr_t p);
        return p.mode == MODE_SVC;
    endfunction

endpackage

// File: rtl/swtrap_decode.sv
module swtrap_decode
    import swtrap_pkg::*;
(
    input  logic insn_vld,
    input  logic is_trap,
    input  logic is_ret,
    input  logic cond_ok,
    output ev_e  ev
);
    logic taken;

    assign taken = insn_vld && cond_ok;

    always_comb begin
        ev = EV_NONE;
        if (taken) begin
            if (is_trap)     ev = EV_TRAP;
            else if (is_ret) ev = EV_RET;
        end
    end
endmodule

// File: rtl/swtrap_psr.sv
module swtrap_psr
    import swtrap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ev_e        ev,
    input  psr_t       saved_psr,
    input  logic       flag_wr,
    input  logic [3:0] flag_val,
    output psr_t       cpsr_q,
    output logic       in_svc
);
    psr_t cpsr_d;

    assign in_svc = is_svc(cpsr_q);

    always_comb begin
        cpsr_d = cpsr_q;
        unique case (ev)
            EV_TRAP: cpsr_d = enter_svc(cpsr_q);
            EV_RET:  if (in_svc) cpsr_d = saved_psr;
            default: if (flag_wr) cpsr_d.nzcv = flag_val;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cpsr_q <= PSR_RESET;
        else     cpsr_q <= cpsr_d;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_NONE && !flag_wr) |=> $stable(cpsr_q)); // R8

    AST_TRAP_MODE: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_TRAP) |=> (cpsr_q.mode == MODE_SVC && cpsr_q.irq_off
                             && cpsr_q.nzcv == $past(cpsr_q.nzcv))); // R4
endmodule

// File: rtl/swtrap_bank.sv
module swtrap_bank
    import swtrap_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  ev_e           ev,
    input  logic          in_svc,
    input  logic [DW-1:0] link_addr,
    input  psr_t          cpsr_now,
    input  logic          lr_wr,
    input  logic [DW-1:0] lr_val,
    output logic [DW-1:0] lr_usr_q,
    output logic [DW-1:0] lr_svc_q,
    output psr_t          spsr_q
);
    localparam int NUM_BANKS = 2;
    localparam int BANK_USR  = 0;
    localparam int BANK_SVC  = 1;

    logic [NUM_BANKS-1:0][DW-1:0] lr_all;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic          mode_hit;
        logic          we;
        logic [DW-1:0] wdata;
        logic [DW-1:0] lr_r;

        assign mode_hit = (b == BANK_SVC) ? in_svc : !in_svc;
        assign we    = (ev == EV_NONE && lr_wr && mode_hit)
                    || (b == BANK_SVC && ev == EV_TRAP);
        assign wdata = (ev == EV_TRAP) ? link_addr : lr_val;

        always_ff @(posedge clk) begin
            if (rst)     lr_r <= '0;
            else if (we) lr_r <= wdata;
        end

        assign lr_all[b] = lr_r;
    end

    assign lr_usr_q = lr_all[BANK_USR];
    assign lr_svc_q = lr_all[BANK_SVC];

    always_ff @(posedge clk) begin
        if (rst)                 spsr_q <= '0;
        else if (ev == EV_TRAP)  spsr_q <= cpsr_now;
    end

    AST_USR_BANK_KEEP: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_TRAP) |=> $stable(lr_usr_q)); // R5

    AST_TRAP_SAVE: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_TRAP) |=> (spsr_q == $past(cpsr_now))); // R3
endmodule

// File: rtl/swtrap_ctrl.sv
module swtrap_ctrl
    import swtrap_pkg::*;
#(
    parameter int              DW         = 32,
    parameter logic [DW-1:0]   VEC_ADDR   = 32'h0000_0008,
    parameter int              INSN_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          insn_vld,
    input  logic          is_trap,
    input  logic          is_ret,
    input  logic          cond_ok,
    input  logic [DW-1:0] cur_pc,
    input  logic          flag_wr,
    input  logic [3:0]    flag_val,
    input  logic          lr_wr,
    input  logic [DW-1:0] lr_val,
    output logic          pc_redirect,
    output logic [DW-1:0] pc_target,
    output logic [31:0]   cpsr,
    output logic [31:0]   spsr_svc,
    output logic [DW-1:0] lr_usr,
    output logic [DW-1:0] lr_svc
);
    localparam logic [DW-1:0] STEP = DW'(INSN_BYTES);

    ev_e           ev;
    psr_t          cpsr_q;
    psr_t          spsr_q;
    logic          in_svc;
    logic [DW-1:0] link_addr;
    logic [DW-1:0] lr_usr_q;
    logic [DW-1:0] lr_svc_q;
    logic [DW-1:0] ret_addr;

    assign link_addr = cur_pc + STEP;
    assign ret_addr  = in_svc ? lr_svc_q : lr_usr_q;

    swtrap_decode u_decode (
        .insn_vld (insn_vld),
        .is_trap  (is_trap),
        .is_ret   (is_ret),
        .cond_ok  (cond_ok),
        .ev       (ev)
    );

    swtrap_psr u_psr (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .saved_psr (spsr_q),
        .flag_wr   (flag_wr),
        .flag_val  (flag_val),
        .cpsr_q    (cpsr_q),
        .in_svc    (in_svc)
    );

    swtrap_bank #(.DW(DW)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .in_svc    (in_svc),
        .link_addr (link_addr),
        .cpsr_now  (cpsr_q),
        .lr_wr     (lr_wr),
        .lr_val    (lr_val),
        .lr_usr_q  (lr_usr_q),
        .lr_svc_q  (lr_svc_q),
        .spsr_q    (spsr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_redirect <= 1'b0;
            pc_target   <= '0;
        end else begin
            pc_redirect <= (ev != EV_NONE);
            if (ev == EV_TRAP)     pc_target <= VEC_ADDR;
            else if (ev == EV_RET) pc_target <= ret_addr;
        end
    end

    assign cpsr     = cpsr_q;
    assign spsr_svc = spsr_q;
    assign lr_usr   = lr_usr_q;
    assign lr_svc   = lr_svc_q;

    AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (rst)
        (insn_vld && cond_ok && is_trap) |=> (pc_redirect && pc_target == VEC_ADDR)); // R1

    AST_TRAP_LINK: assert property (@(posedge clk) disable iff (rst)
        (insn_vld && cond_ok && is_trap) |=> (lr_svc == $past(cur_pc) + STEP)); // R2

    AST_RET_SVC: assert property (@(posedge clk) disable iff (rst)
        (insn_vld && cond_ok && is_ret && !is_trap && cpsr[4:0] == MODE_SVC)
        |=> (pc_redirect && pc_target == $past(lr_svc) && cpsr == $past(spsr_svc))); // R6

    AST_RET_USR: assert property (@(posedge clk) disable iff (rst)
        (insn_vld && cond_ok && is_ret && !is_trap && cpsr[4:0] == MODE_USR)
        |=> (pc_redirect && pc_target == $past(lr_usr) && $stable(cpsr))); // R7

    AST_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        !(insn_vld && cond_ok) |=> !pc_redirect); // R8
endmodule

// File: tb/swtrap_ctrl_bench.sv
module swtrap_ctrl_bench;

    typedef struct packed {
        logic        redir;
        logic [31:0] tgt;
        logic [31:0] cpsr;
        logic [31:0] spsr;
        logic [31:0] lru;
        logic [31:0] lrs;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_vld = 1'b0, is_trap = 1'b0, is_ret = 1'b0, cond_ok = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        flag_wr = 1'b0;
    logic [3:0]  flag_val = '0;
    logic        lr_wr = 1'b0;
    logic [31:0] lr_val = '0;
    logic        pc_redirect;
    logic [31:0] pc_target, cpsr, spsr_svc, lr_usr, lr_svc;

    int checks = 0;
    int fails  = 0;

    exp_t  exp_q[$];
    string tag_q[$];

    logic [31:0] m_cpsr = 32'h10, m_spsr = '0, m_lru = '0, m_lrs = '0;

    always #10 clk = ~clk;

    swtrap_ctrl u_swtrap_ctrl (
        .clk(clk), .rst(rst), .insn_vld(insn_vld), .is_trap(is_trap),
        .is_ret(is_ret), .cond_ok(cond_ok), .cur_pc(cur_pc),
        .flag_wr(flag_wr), .flag_val(flag_val), .lr_wr(lr_wr), .lr_val(lr_val),
        .pc_redirect(pc_redirect), .pc_target(pc_target), .cpsr(cpsr),
        .spsr_svc(spsr_svc), .lr_usr(lr_usr), .lr_svc(lr_svc)
    );

    task automatic step(input logic v, input logic t, input logic r, input logic c,
                        input logic [31:0] pc, input logic fw, input logic [3:0] fv,
                        input logic lw, input logic [31:0] lv, input string tag);
        exp_t e;
        @(negedge clk);
        insn_vld = v; is_trap = t; is_ret = r; cond_ok = c; cur_pc = pc;
        flag_wr = fw; flag_val = fv; lr_wr = lw; lr_val = lv;
        e.redir = 1'b0;
        e.tgt   = '0;
        if (v && c && t) begin
            m_spsr = m_cpsr;
            m_lrs  = pc + 32'd4;
            m_cpsr = {m_cpsr[31:8], 1'b1, m_cpsr[6:5], 5'h13};
            e.redir = 1'b1;
            e.tgt   = 32'h8;
        end else if (v && c && r) begin
            e.redir = 1'b1;
            if (m_cpsr[4:0] == 5'h13) begin
                e.tgt  = m_lrs;
                m_cpsr = m_spsr;
            end else begin
                e.tgt = m_lru;
            end
        end else begin
            if (lw) begin
                if (m_cpsr[4:0] == 5'h13) m_lrs = lv;
                else                      m_lru = lv;
            end
            if (fw) m_cpsr[31:28] = fv;
        end
        e.cpsr = m_cpsr; e.spsr = m_spsr; e.lru = m_lru; e.lrs = m_lrs;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 4'h0, 1'b0, 32'h0, "R8 idle");
    endtask

    // monitor: compares one expected item per cycle after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t  e;
                exp_t  a;
                string tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                a.redir = pc_redirect;
                a.tgt   = e.redir ? pc_target : '0;
                a.cpsr  = cpsr; a.spsr = spsr_svc; a.lru = lr_usr; a.lrs = lr_svc;
                checks++;
                if (a !== e) begin
                    fails++;
                    $display("FAIL %s: actual redir=%0b tgt=%h cpsr=%h spsr=%h lru=%h lrs=%h expected redir=%0b tgt=%h cpsr=%h spsr=%h lru=%h lrs=%h",
                             tg, a.redir, a.tgt, a.cpsr, a.spsr, a.lru, a.lrs,
                             e.redir, e.tgt, e.cpsr, e.spsr, e.lru, e.lrs);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        checks++; // R10 reset state
        if (pc_redirect !== 1'b0 || cpsr !== 32'h10 || spsr_svc !== 32'h0
            || lr_usr !== 32'h0 || lr_svc !== 32'h0) begin
            fails++;
            $display("FAIL R10: actual redir=%0b cpsr=%h spsr=%h lru=%h lrs=%h expected 0 00000010 0 0 0",
                     pc_redirect, cpsr, spsr_svc, lr_usr, lr_svc);
        end

        // R11 user-mode write-back and flags
        step(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 4'h0, 1'b1, 32'h003F_FFF0, "R11 lr_usr write");
        step(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 4'h1, 1'b0, 32'h0, "R11 flag write");
        // R8 suppressed requests
        step(1'b1, 1'b1, 1'b0, 1'b0, 32'h100, 1'b0, 4'h0, 1'b0, 32'h0, "R8 trap cond fail");
        step(1'b0, 1'b1, 1'b1, 1'b1, 32'h104, 1'b0, 4'h0, 1'b0, 32'h0, "R8 trap not valid");
        step(1'b1, 1'b0, 1'b1, 1'b0, 32'h108, 1'b0, 4'h0, 1'b0, 32'h0, "R8 ret cond fail");
        // R1 R2 R3 R4 R5 trap from user mode
        step(1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_8000, 1'b0, 4'h0, 1'b0, 32'h0, "R1 R2 R3 R4 R5 trap");
        idle();
        // R11 supervisor-mode write-back lands in supervisor bank
        step(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 4'h8, 1'b1, 32'h0000_9004, "R11 svc writes");
        // R6 return from supervisor mode
        step(1'b1, 1'b0, 1'b1, 1'b1, 32'h20, 1'b0, 4'h0, 1'b0, 32'h0, "R6 svc return");
        idle();
        // R7 return in user mode
        step(1'b1, 1'b0, 1'b1, 1'b1, 32'h200, 1'b0, 4'h0, 1'b0, 32'h0, "R7 user return");
        // R9 trap beats return, and beats concurrent writes
        step(1'b1, 1'b1, 1'b1, 1'b1, 32'h300, 1'b1, 4'hF, 1'b1, 32'hDEAD_BEEF, "R9 trap priority");
        // R3 nested trap from supervisor mode saves supervisor status
        step(1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_0010, 1'b0, 4'h0, 1'b0, 32'h0, "R3 nested trap");
        // R9 return discards concurrent writes
        step(1'b1, 1'b0, 1'b1, 1'b1, 32'h14, 1'b1, 4'h6, 1'b1, 32'h1234_5678, "R9 ret priority");
        step(1'b1, 1'b0, 1'b1, 1'b1, 32'h304, 1'b0, 4'h0, 1'b0, 32'h0, "R6 unwind");
        // R2 wrap at top of address space
        step(1'b1, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFC, 1'b0, 4'h0, 1'b0, 32'h0, "R2 wrap trap");
        step(1'b1, 1'b0, 1'b1, 1'b1, 32'h8, 1'b0, 4'h0, 1'b0, 32'h0, "R6 wrap return");
        // mixed pattern: traps and returns at varied addresses
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 4'(i), 1'b1, 32'h4000 + 32'(i * 16), "R11 loop write");
            step(1'b1, 1'b1, 1'b0, 1'b1, 32'h1000 + 32'(i * 8), 1'b0, 4'h0, 1'b0, 32'h0, "R1 R4 loop trap");
            step(1'b1, 1'b0, 1'b1, (i % 3) != 0, 32'h8, 1'b0, 4'h0, 1'b0, 32'h0, "R6 R8 loop return");
        end
        idle();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule